// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block sits on the controller side of a multiplexed-address asynchronous DRAM. After reset it keeps the row strobe idle for a power-up pause. It then runs a warm-up burst of complete row-strobe cycles, which needs no arbitration. After the burst it reports the memory usable. From then on it keeps the stored data alive with row-strobe-only refresh cycles. The column strobe stays inactive during these cycles, and a row counter walks every row once per retention period.

Refresh work is spread evenly. One refresh becomes due every retention period divided by the number of rows. Due refreshes wait in a saturating backlog counter. Each one is offered to the access arbiter over a request/grant handshake. `ref_req` is the valid side and `ref_gnt` is the ready side. A refresh starts on a cycle where both are high. Once raised, `ref_req` stays high until it is granted, because the backlog cannot shrink without a grant. The arbiter may hold `ref_gnt` high at any time: while `ref_req` is low, `ref_gnt` is ignored. While `ref_busy` is high, the block owns the strobe and address pins.

If the arbiter starves the block for a full retention period, the memory is treated as having lost its dynamic state. Ready drops and the warm-up burst runs again. All timing is set through parameters: the pause and the retention period in microseconds, the clock in MHz, and the address setup, strobe-low and precharge times in clock cycles.

Top module: `dram_ref_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, `ras_n`=1, `cas_n`=1, `ref_req`=0, `ref_busy`=0, `mem_ready`=0 and `addr`=0.
- R2: `ras_n` stays 1 for the first PAUSE_US*CLK_MHZ clock edges after reset is released. The first warm-up cycle starts on the next edge.
- R3: The warm-up burst is WARMUP strobe cycles, each followed by one idle cycle, and it needs no grant. `mem_ready` rises on the edge at which the last warm-up cycle finishes.
- R4: A strobe cycle keeps `ref_busy`=1 for T_ASR+T_RAS+T_RP cycles. During these cycles `addr` is driven for T_ASR cycles with `ras_n`=1, then `ras_n`=0 for T_RAS cycles with `addr` unchanged, then `ras_n`=1 for T_RP cycles.
- R5: `cas_n` is 1 at all times.
- R6: While ready, a refresh becomes due every (RETAIN_US*CLK_MHZ)>>ROW_W cycles, counted from the cycle ready rose. `ref_req` = ready AND backlog≠0 AND not busy.
- R7: A refresh starts, and one unit of backlog is consumed, on a cycle where `ref_req` and `ref_gnt` are both 1. `ref_req` does not drop until it is granted, except on a retention timeout (R10). `ref_gnt` has no effect while `ref_req` is 0.
- R8: Each strobe cycle drives the row counter on `addr[ROW_W-1:0]`, with the upper `addr` bits at 0. Each granted refresh advances the counter by one, wrapping from 2^ROW_W-1 to 0. Warm-up cycles do not advance it.
- R9: The backlog saturates at 2^PEND_W-1. Due refreshes beyond that are dropped. A backlog drains back-to-back, with one idle cycle between cycles.
- R10: If RETAIN_US*CLK_MHZ consecutive ready cycles pass with no strobe cycle running and none starting, `mem_ready` drops and the backlog clears. The warm-up burst then repeats before ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Arbiter grant (ready side of the refresh handshake) |
| ref_req | output | 1 | Refresh request (valid side) |
| ref_busy | output | 1 | Strobe cycle in progress; block owns the DRAM pins |
| mem_ready | output | 1 | Memory initialised and usable by the arbiter |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, held inactive |
| addr | output | ADDR_W | Multiplexed address pins |

## Verification
The assertions assume that `rst_n` is synchronous and that `ref_gnt` is a plain level. The arbiter may raise `ref_gnt` at any time, including while `ref_req` is low. The assertions also assume the timing parameters are at least 1, and that the refresh interval is longer than one strobe cycle. The stimulus drives `ref_gnt` one step after each rising edge. It covers a constant grant, grant withheld long enough to build and saturate the backlog, starvation beyond the retention period, and a random toggle pattern. The bench overrides the parameters with short times, so that a full row wrap, a saturated backlog and a retention timeout all occur within the run.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_WARM,
    PH_RUN
  } phase_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_ACT,
    SQ_PRE
  } seq_e;
endpackage

// File: rtl/ras_seq.sv
module ras_seq
  import dram_ref_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int ROW_W  = 8,
  parameter int T_ASR  = 2,
  parameter int T_RAS  = 8,
  parameter int T_RP   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROW_W-1:0]  row,
  output logic              ras_n,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done
);
  localparam int TMAX = (T_ASR > T_RAS) ? ((T_ASR > T_RP) ? T_ASR : T_RP)
                                        : ((T_RAS > T_RP) ? T_RAS : T_RP);
  localparam int CW = $clog2(TMAX + 1);

  seq_e          st;
  logic [CW-1:0] cnt;

  assign busy = (st != SQ_IDLE);
  assign done = (st == SQ_PRE) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      addr  <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (start) begin
            st   <= SQ_SETUP;
            cnt  <= CW'(T_ASR - 1);
            addr <= ADDR_W'(row);
          end
        end
        SQ_SETUP: begin
          if (cnt == '0) begin
            st    <= SQ_ACT;
            cnt   <= CW'(T_RAS - 1);
            ras_n <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_ACT: begin
          if (cnt == '0) begin
            st    <= SQ_PRE;
            cnt   <= CW'(T_RP - 1);
            ras_n <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) st <= SQ_IDLE;
          else           cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  logic [15:0] low_len;
  always_ff @(posedge clk) begin
    if (!rst_n)     low_len <= '0;
    else if (ras_n) low_len <= '0;
    else            low_len <= low_len + 1'b1;
  end

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> $stable(addr));

  // R4
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_len == 16'(T_RAS)));
endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
  parameter int INTERVAL = 1562,
  parameter int PEND_W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic take,
  output logic pend_nz
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

  logic [TW-1:0]     tcnt;
  logic [PEND_W-1:0] pend;
  logic              tick;

  assign tick    = en && (tcnt == TW'(INTERVAL - 1));
  assign pend_nz = (pend != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !en || clr) tcnt <= '0;
    else if (tick)            tcnt <= '0;
    else                      tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pend <= '0;
    end else if (en) begin
      case ({tick, take})
        2'b10:   if (pend != PMAX) pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  // R9
  pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == PMAX && tick && !take && !clr) |=> (pend == PMAX));

  // R7
  take_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend_nz);
endmodule

// File: rtl/dram_ref_sched.sv
module dram_ref_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int PAUSE_US  = 200,
  parameter int RETAIN_US = 4000,
  parameter int WARMUP    = 8,
  parameter int ROW_W     = 8,
  parameter int ADDR_W    = 9,
  parameter int T_ASR     = 2,
  parameter int T_RAS     = 8,
  parameter int T_RP      = 6,
  parameter int PEND_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              ref_busy,
  output logic              mem_ready,
  output logic              ras_n,
  output logic              cas_n,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAUSE_CYC  = PAUSE_US * CLK_MHZ;
  localparam int RETAIN_CYC = RETAIN_US * CLK_MHZ;
  localparam int INTERVAL   = RETAIN_CYC >> ROW_W;
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int RW = $clog2(RETAIN_CYC + 1);
  localparam int WW = $clog2(WARMUP + 1);

  phase_e           state;
  logic [PW-1:0]    pause_cnt;
  logic [WW-1:0]    warm_cnt;
  logic [RW-1:0]    idle_cnt;
  logic [ROW_W-1:0] row_q;
  logic             seq_busy, seq_done, seq_start;
  logic             pend_nz, take, expire;

  assign mem_ready = (state == PH_RUN);
  assign ref_req   = mem_ready && pend_nz && !seq_busy;
  assign take      = ref_req && ref_gnt;
  assign seq_start = ((state == PH_WARM) && !seq_busy) || take;
  assign expire    = mem_ready && !take && !seq_busy &&
                     (idle_cnt == RW'(RETAIN_CYC - 1));
  assign ref_busy  = seq_busy;
  assign cas_n     = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= PH_PAUSE;
      pause_cnt <= '0;
      warm_cnt  <= '0;
      idle_cnt  <= '0;
    end else begin
      case (state)
        PH_PAUSE: begin
          if (pause_cnt == PW'(PAUSE_CYC - 1)) state <= PH_WARM;
          else                                 pause_cnt <= pause_cnt + 1'b1;
        end
        PH_WARM: begin
          if (seq_done) begin
            if (warm_cnt == WW'(WARMUP - 1)) begin
              state    <= PH_RUN;
              warm_cnt <= '0;
              idle_cnt <= '0;
            end else begin
              warm_cnt <= warm_cnt + 1'b1;
            end
          end
        end
        default: begin
          if (expire) begin
            state    <= PH_WARM;
            idle_cnt <= '0;
          end else if (take || seq_busy) begin
            idle_cnt <= '0;
          end else begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    row_q <= '0;
    else if (take) row_q <= row_q + 1'b1;
  end

  ref_backlog #(.INTERVAL(INTERVAL), .PEND_W(PEND_W)) u_backlog (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (mem_ready),
    .clr     (expire),
    .take    (take),
    .pend_nz (pend_nz)
  );

  ras_seq #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .T_ASR(T_ASR),
            .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (seq_start),
    .row   (row_q),
    .ras_n (ras_n),
    .addr  (addr),
    .busy  (seq_busy),
    .done  (seq_done)
  );

  // R2
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_PAUSE) |-> (ras_n && !seq_busy));

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt && !expire) |=> ref_req);

  // R8
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (row_q == $past(row_q) + 1'b1));

  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ready) |-> (ras_n && !seq_busy && !ref_req));

  // R3
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> ($past(seq_done) && !seq_busy));
endmodule

// File: tb/dram_ref_sched_bench.sv
module dram_ref_sched_bench;
  localparam int CLK_MHZ = 200, PAUSE_US = 2, RETAIN_US = 64, WARMUP = 8;
  localparam int ROW_W = 8, ADDR_W = 9, T_ASR = 2, T_RAS = 6, T_RP = 4, PEND_W = 4;
  localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int RETAIN_CYC = RETAIN_US * CLK_MHZ;
  localparam int INTERVAL = RETAIN_CYC >> ROW_W;
  localparam int B = T_ASR + T_RAS + T_RP;
  localparam int PMAX = (1 << PEND_W) - 1;

  logic clk = 0, rst_n = 0, ref_gnt = 0;
  logic ref_req, ref_busy, mem_ready, ras_n, cas_n;
  logic [ADDR_W-1:0] addr;

  always #2.5 clk = ~clk;

  dram_ref_sched #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .RETAIN_US(RETAIN_US),
    .WARMUP(WARMUP), .ROW_W(ROW_W), .ADDR_W(ADDR_W), .T_ASR(T_ASR),
    .T_RAS(T_RAS), .T_RP(T_RP), .PEND_W(PEND_W)) u_dram_ref_sched (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_busy(ref_busy), .mem_ready(mem_ready), .ras_n(ras_n),
    .cas_n(cas_n), .addr(addr));

  int total = 0, bad = 0, cycles = 0;
  int ph = 0, pc = 0, s = -1, row = 0, maddr = 0, wc = 0, pend = 0, tc = 0, idle = 0;
  int m_takes = 0, d_takes = 0, d_falls = 0;
  logic prev_ready = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d cycle=%0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; pc = 0; s = -1; row = 0; maddr = 0; wc = 0; pend = 0; tc = 0; idle = 0;
    end else begin
      int s_old;
      bit req_c, tk, st, dn, tick, exp_t;
      s_old = s;
      req_c = (ph == 2) && (pend > 0) && (s_old < 0);
      tk = req_c && ref_gnt;
      st = ((ph == 1) && (s_old < 0)) || tk;
      dn = (s_old == B - 1);
      if (tk) m_takes++;
      if (st) begin s = 0; maddr = row; end
      else if (s_old >= 0) s = (s_old == B - 1) ? -1 : s_old + 1;
      if (ph == 0) begin
        pc++;
        if (pc == PAUSE_CYC) ph = 1;
      end else if (ph == 1) begin
        if (dn) begin
          wc++;
          if (wc == WARMUP) begin ph = 2; wc = 0; tc = 0; idle = 0; pend = 0; end
        end
      end else begin
        tick = (tc == INTERVAL - 1);
        tc = tick ? 0 : tc + 1;
        exp_t = !tk && (s_old < 0) && (idle == RETAIN_CYC - 1);
        if (tk || s_old >= 0) idle = 0; else idle++;
        if (tick && !tk && pend < PMAX) pend++;
        else if (tk && !tick) pend--;
        if (tk) row = (row + 1) % (1 << ROW_W);
        if (exp_t) begin ph = 1; wc = 0; pend = 0; tc = 0; idle = 0; end
      end
    end
  end

  // comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      int eras;
      string rtag;
      cycles++;
      eras = (s >= T_ASR && s < T_ASR + T_RAS) ? 0 : 1;
      rtag = (ph == 0) ? "R2" : ((ph == 1) ? "R3" : "R4");
      chk(rtag, ras_n, eras);
      chk("R4", ref_busy, (s >= 0) ? 1 : 0);
      chk("R5", cas_n, 1);
      chk("R8", addr, maddr);
      chk("R6", ref_req, ((ph == 2) && pend > 0 && s < 0) ? 1 : 0);
      chk("R3", mem_ready, (ph == 2) ? 1 : 0);
      if (ref_req && ref_gnt) d_takes++;
      if (prev_ready && !mem_ready) d_falls++;
      prev_ready = mem_ready;
    end
  end

  task automatic drive(bit v, int n);
    repeat (n) begin @(posedge clk); #1 ref_gnt = v; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", ras_n, 1); chk("R1", cas_n, 1); chk("R1", ref_req, 0);
    chk("R1", ref_busy, 0); chk("R1", mem_ready, 0); chk("R1", addr, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk("R1", ras_n, 1); chk("R1", mem_ready, 0);
    // constant grant: grant with no request is ignored, rows wrap
    drive(1, 14000);
    chk("R7", d_takes, m_takes);
    chk("R8", (m_takes > (1 << ROW_W)) ? 1 : 0, 1);
    // short starvation, then drain
    drive(0, 300); drive(1, 400);
    chk("R7", d_takes, m_takes);
    // backlog saturation, then drain
    drive(0, 1000);
    m_takes = 0; d_takes = 0;
    drive(1, 500);
    chk("R9", d_takes, m_takes);
    chk("R9", (d_takes >= PMAX) ? 1 : 0, 1);
    // retention timeout
    d_falls = 0;
    drive(0, 13000);
    chk("R10", d_falls, 1);
    drive(1, 2000);
    @(negedge clk);
    chk("R10", mem_ready, 1);
    // random grant pattern
    m_takes = 0; d_takes = 0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1 ref_gnt = 1'($urandom % 2);
    end
    @(negedge clk);
    chk("R7", d_takes, m_takes);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule